// File: doc/BRIEF.md
# Configurable I/O Pin Multiplexer

This block sits between a row of chip pads and the wires of on-chip peripheral functions. Each pad is modelled with three signals: the value read from the pad, the value driven onto it, and an output-enable. Whenever output-enable is low, the pad acts as an input. Every pad owns a small configuration register. That register holds a source select code and a plain GPIO output bit and enable bit.

A select code of zero hands the pad to its GPIO bits. Codes 1 to 3 hand it to a peripheral function. The same code picks both the driven value and the output-enable, so a bidirectional function can turn the pad around by itself.

On the input side, every pad that currently selects a function is a candidate source for that function's input wire. A lowest-index priority resolver passes exactly one of them. A function input with no candidate reads a fixed idle level. All routing is combinational. Only the configuration registers are clocked.

Top module: `pinmux_top`

## Requirements
- R1: After reset, every pad selects GPIO with GPIO enable and GPIO data cleared, so every `pad_oe` bit and every `pad_out` bit reads 0 whatever the function wires carry.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register of pad `cfg_addr` at that clock edge. The fields are: bits [3:2] select code, bit [1] GPIO output-enable, bit [0] GPIO output value. The new setting is visible at the pads from that edge on.
- R3: A write to an address equal to or above `NUM_PADS` changes no register, so no pad output or function input changes as a result.
- R4: A pad with select code 0 drives `pad_out` from its GPIO value bit and `pad_oe` from its GPIO enable bit.
- R5: A pad p with select code s in 1..3 is connected to function (p + s - 1) mod `NUM_FUNCS`. Both its `pad_out` and its `pad_oe` come from that function's `fn_out` and `fn_oe` bits.
- R6: One function output may drive several pads at the same time, and each of those pads carries the same value and enable.
- R7: `fn_in[f]` equals `pad_in` of the lowest-numbered pad whose select code reaches function f.
- R8: A function that no pad reaches reads its idle level `FN_IDLE[f]`. A pad on select code 0 reaches no function.
- R9: The routing paths from `fn_out`/`fn_oe` to the pads, and from `pad_in` to `fn_in`, are combinational. They follow input changes within the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Pad number to write |
| cfg_wdata | input | 4 | {select[1:0], gpio_oe, gpio_out} |
| fn_out | input | NUM_FUNCS | Output value of each function |
| fn_oe | input | NUM_FUNCS | Output-enable of each function |
| fn_in | output | NUM_FUNCS | Input delivered to each function |
| pad_in | input | NUM_PADS | Value read from each pad |
| pad_out | output | NUM_PADS | Value driven onto each pad |
| pad_oe | output | NUM_PADS | Output-enable of each pad |

## Verification
The bench builds the block with five pads, three functions and an idle pattern of 3'b010. Because five is not a power of two, the three-bit address has unused codes 5 to 7, which exercise the ignored-write path. With three functions and three function codes per pad, several pads can reach one function through different codes, so the resolver faces up to five competing candidates. The mixed idle pattern tells an unclaimed input reading 1 apart from one reading 0.

// File: rtl/pmux_pkg.sv
package pmux_pkg;

    localparam int SRC_SEL_W = 2;
    localparam int CFG_W     = SRC_SEL_W + 2;
    localparam logic [SRC_SEL_W-1:0] SRC_GPIO = '0;

    typedef struct packed {
        logic [SRC_SEL_W-1:0] sel;
        logic                 gpio_oe;
        logic                 gpio_out;
    } pad_cfg_t;

    // Function reached by pad "pad" when its select code is "code" (code > 0)
    function automatic int route_fn(input int pad, input int code, input int nfunc);
        return (pad + code - 1) % nfunc;
    endfunction

endpackage

// File: rtl/pmux_cfg_regs.sv
module pmux_cfg_regs
    import pmux_pkg::*;
#(
    parameter int NUM_PADS = 4,
    parameter int ADDR_W   = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  pad_cfg_t                     wdata,
    output pad_cfg_t [NUM_PADS-1:0]      cfg
);

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[p] <= '0;
            end else if (we && (addr == ADDR_W'(p))) begin
                cfg[p] <= wdata;
            end
        end
    end

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && (int'(addr) < NUM_PADS)) |=> (cfg[$past(addr)] == $past(wdata))); // R2

    AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (we && (int'(addr) >= NUM_PADS)) |=> $stable(cfg)); // R3

    AST_RESET_GPIO: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg == '0)); // R1

endmodule

// File: rtl/pmux_pad_drive.sv
module pmux_pad_drive
    import pmux_pkg::*;
#(
    parameter int PAD_IDX   = 0,
    parameter int NUM_FUNCS = 4
) (
    input  pad_cfg_t               cfg,
    input  logic [NUM_FUNCS-1:0]   fn_out,
    input  logic [NUM_FUNCS-1:0]   fn_oe,
    output logic                   pad_out,
    output logic                   pad_oe
);

    int fidx;

    always_comb begin
        fidx = route_fn(PAD_IDX, int'(cfg.sel), NUM_FUNCS);
        if (cfg.sel == SRC_GPIO) begin
            pad_out = cfg.gpio_out;
            pad_oe  = cfg.gpio_oe;
        end else begin
            pad_out = fn_out[fidx];
            pad_oe  = fn_oe[fidx];
        end
    end

endmodule

// File: rtl/pmux_in_resolve.sv
module pmux_in_resolve
    import pmux_pkg::*;
#(
    parameter int                   NUM_PADS  = 4,
    parameter int                   NUM_FUNCS = 4,
    parameter logic [NUM_FUNCS-1:0] FN_IDLE   = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  pad_cfg_t [NUM_PADS-1:0]   cfg,
    input  logic [NUM_PADS-1:0]       pad_in,
    output logic [NUM_FUNCS-1:0]      fn_in
);

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
        logic [NUM_PADS-1:0] claim;
        logic [NUM_PADS-1:0] grant;

        // per-pad comparators: does this pad's select reach function f?
        for (genvar p = 0; p < NUM_PADS; p++) begin : g_cmp
            assign claim[p] = (cfg[p].sel != SRC_GPIO) &&
                              (route_fn(p, int'(cfg[p].sel), NUM_FUNCS) == f);
        end

        // isolate the lowest set claim bit
        assign grant = claim & (~claim + NUM_PADS'(1));

        assign fn_in[f] = (claim == '0) ? FN_IDLE[f] : |(grant & pad_in);

        AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
            $onehot0(grant) && ((claim == '0) == (grant == '0))); // R7

        AST_IDLE_UNCLAIMED: assert property (@(posedge clk) disable iff (rst)
            (claim == '0) |-> (fn_in[f] == FN_IDLE[f])); // R8
    end

endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
    import pmux_pkg::*;
#(
    parameter int                   NUM_PADS  = 4,
    parameter int                   NUM_FUNCS = 4,
    parameter logic [NUM_FUNCS-1:0] FN_IDLE   = '0,
    localparam int                  ADDR_W    = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [CFG_W-1:0]       cfg_wdata,
    input  logic [NUM_FUNCS-1:0]   fn_out,
    input  logic [NUM_FUNCS-1:0]   fn_oe,
    output logic [NUM_FUNCS-1:0]   fn_in,
    input  logic [NUM_PADS-1:0]    pad_in,
    output logic [NUM_PADS-1:0]    pad_out,
    output logic [NUM_PADS-1:0]    pad_oe
);

    pad_cfg_t [NUM_PADS-1:0] cfg;

    pmux_cfg_regs #(
        .NUM_PADS (NUM_PADS),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (pad_cfg_t'(cfg_wdata)),
        .cfg   (cfg)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        pmux_pad_drive #(
            .PAD_IDX   (p),
            .NUM_FUNCS (NUM_FUNCS)
        ) u_drive (
            .cfg     (cfg[p]),
            .fn_out  (fn_out),
            .fn_oe   (fn_oe),
            .pad_out (pad_out[p]),
            .pad_oe  (pad_oe[p])
        );

        AST_FN_OWNS_PAD: assert property (@(posedge clk) disable iff (rst)
            (cfg[p].sel != SRC_GPIO) |->
            ((pad_out[p] == fn_out[route_fn(p, int'(cfg[p].sel), NUM_FUNCS)]) &&
             (pad_oe[p]  == fn_oe[route_fn(p, int'(cfg[p].sel), NUM_FUNCS)]))); // R5

        AST_GPIO_OWNS_PAD: assert property (@(posedge clk) disable iff (rst)
            (cfg[p].sel == SRC_GPIO) |->
            ((pad_out[p] == cfg[p].gpio_out) && (pad_oe[p] == cfg[p].gpio_oe))); // R4
    end

    pmux_in_resolve #(
        .NUM_PADS  (NUM_PADS),
        .NUM_FUNCS (NUM_FUNCS),
        .FN_IDLE   (FN_IDLE)
    ) u_resolve (
        .clk    (clk),
        .rst    (rst),
        .cfg    (cfg),
        .pad_in (pad_in),
        .fn_in  (fn_in)
    );

endmodule

// File: tb/sim_pinmux_top.sv
`timescale 1ns/1ps
module sim_pinmux_top;

    localparam int NP = 5;
    localparam int NF = 3;
    localparam logic [NF-1:0] IDLE = 3'b010;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [3:0]    cfg_wdata = '0;
    logic [NF-1:0] fn_out = '0;
    logic [NF-1:0] fn_oe = '0;
    logic [NF-1:0] fn_in;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int total = 0;
    int bad = 0;

    int m_sel [NP];
    int m_oe  [NP];
    int m_out [NP];

    always #5 clk = ~clk;

    pinmux_top #(.NUM_PADS(NP), .NUM_FUNCS(NF), .FN_IDLE(IDLE)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input logic got, input logic exp, input string tag, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // behavioural reference comparison of every output
    task automatic cmp_all();
        for (int p = 0; p < NP; p++) begin
            logic eo, ee;
            if (m_sel[p] == 0) begin
                eo = m_out[p][0];
                ee = m_oe[p][0];
                chk(pad_out[p], eo, "R4", $sformatf("pad_out[%0d]", p));
                chk(pad_oe[p],  ee, "R4", $sformatf("pad_oe[%0d]", p));
            end else begin
                int f = (p + m_sel[p] - 1) % NF;
                chk(pad_out[p], fn_out[f], "R5", $sformatf("pad_out[%0d]", p));
                chk(pad_oe[p],  fn_oe[f],  "R5", $sformatf("pad_oe[%0d]", p));
            end
        end
        for (int f = 0; f < NF; f++) begin
            int src = -1;
            for (int p = NP - 1; p >= 0; p--)
                if (m_sel[p] != 0 && ((p + m_sel[p] - 1) % NF) == f) src = p;
            if (src < 0) chk(fn_in[f], IDLE[f], "R8", $sformatf("fn_in[%0d]", f));
            else         chk(fn_in[f], pad_in[src], "R7", $sformatf("fn_in[%0d]", f));
        end
    endtask

    task automatic step(input bit we, input int addr, input int data,
                        input int fo, input int foe, input int pin);
        @(negedge clk);
        cfg_we    = we;
        cfg_addr  = 3'(addr);
        cfg_wdata = 4'(data);
        fn_out    = NF'(fo);
        fn_oe     = NF'(foe);
        pad_in    = NP'(pin);
        #1 cmp_all();
        @(posedge clk);
        if (we && addr < NP) begin
            m_sel[addr] = (data >> 2) & 3;
            m_oe[addr]  = (data >> 1) & 1;
            m_out[addr] = data & 1;
        end
        #1;
        cfg_we = 1'b0;
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_sel[p] = 0; m_oe[p] = 0; m_out[p] = 0;
        end
        fn_out = '1; fn_oe = '1; pad_in = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int p = 0; p < NP; p++) begin
            chk(pad_oe[p],  1'b0, "R1", $sformatf("pad_oe[%0d] after reset", p));
            chk(pad_out[p], 1'b0, "R1", $sformatf("pad_out[%0d] after reset", p));
        end
        for (int f = 0; f < NF; f++)
            chk(fn_in[f], IDLE[f], "R8", $sformatf("fn_in[%0d] after reset", f));

        // R2: GPIO drive on pad 2, visible right after the edge
        step(1, 2, 4'b0011, 0, 0, 0);
        chk(pad_oe[2], 1'b1, "R2", "pad_oe[2] after write");
        chk(pad_out[2], 1'b1, "R2", "pad_out[2] after write");

        // R3: writes to unused addresses 5..7
        step(1, 5, 4'b1111, 0, 0, 0);
        step(1, 7, 4'b0110, 0, 0, 0);
        chk(pad_oe[2], 1'b1, "R3", "pad_oe[2] after bad-address write");
        chk(pad_oe[0], 1'b0, "R3", "pad_oe[0] after bad-address write");
        chk(fn_in[1], IDLE[1], "R3", "fn_in[1] after bad-address write");

        // R6: function 1 drives pad 0 (code 2) and pad 2 (code 3)
        step(1, 0, 4'b1000, 0, 0, 0);
        step(1, 2, 4'b1100, 3'b010, 3'b010, 0);
        chk(pad_out[0], 1'b1, "R6", "pad_out[0] from fn 1");
        chk(pad_out[2], 1'b1, "R6", "pad_out[2] from fn 1");
        chk(pad_oe[0],  1'b1, "R6", "pad_oe[0] from fn 1");
        chk(pad_oe[2],  1'b1, "R6", "pad_oe[2] from fn 1");

        // R7: pads 4 (code 1 -> f1) also claims f1; lowest (pad 0) wins
        step(1, 4, 4'b0100, 0, 0, 5'b10100);
        step(0, 0, 0, 0, 0, 5'b10100);
        chk(fn_in[1], 1'b0, "R7", "fn_in[1] follows pad 0");
        step(0, 0, 0, 0, 0, 5'b00001);
        chk(fn_in[1], 1'b1, "R7", "fn_in[1] follows pad 0 high");

        // R9: combinational paths, no clock edge between change and sample
        @(negedge clk);
        pad_in = 5'b00000;
        fn_out = 3'b000;
        #1;
        chk(fn_in[1],   1'b0, "R9", "fn_in[1] same-cycle");
        chk(pad_out[2], 1'b0, "R9", "pad_out[2] same-cycle");
        pad_in = 5'b00001;
        fn_out = 3'b010;
        #1;
        chk(fn_in[1],   1'b1, "R9", "fn_in[1] same-cycle rise");
        chk(pad_out[2], 1'b1, "R9", "pad_out[2] same-cycle rise");

        // mixed traffic against the reference model
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 3) == 0, int'($urandom % 8), int'($urandom % 16),
                 int'($urandom % 8), int'($urandom % 8), int'($urandom % 32));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule